// File: doc/BRIEF.md
# Cache Error Trap Routing Unit

This block sits between the error detectors of an external cache and system bus port and the processor's trap logic. Each cycle it accepts up to `NLANE` error reports. Each report carries three codes: a class (hardware-corrected, software-correctable, uncorrectable, timeout or bus error), a source (cache data, cache tag, bus data or bus tag) and the operation that was running when the error was found. From these codes and from a software-written enable register, it decides which trap to raise. Every valid report also sets a sticky, write-one-to-clear status bit, whether or not its trap is enabled.

There are two kinds of trap. A synchronous trap is a one-cycle pulse, and only one fires per cycle. There are three of them: a fast cache-error trap, an instruction-access trap and a data-access trap. The disrupting ECC trap is a level that stays up until software acknowledges it. It is tracked by a three-state machine:
- `DS_IDLE`: nothing is pending.
- `DS_PEND`: the trap is pending and `trap_disr` is high.
- `DS_HELD`: the trap is pending, but a synchronous trap fires in the same cycle, so `trap_disr` is held low.

Its transitions are:
- `DS_IDLE` goes to `DS_PEND` on a disrupting hit, or to `DS_HELD` when the hit comes together with a synchronous hit.
- `DS_PEND` goes to `DS_IDLE` on an acknowledge with no new hit.
- `DS_PEND` goes to `DS_HELD` on any synchronous hit.
- `DS_HELD` goes back to `DS_PEND` on the first cycle with no synchronous hit.

The same enable register also holds two fault-injection fields. When a force bit is set, its forced check value replaces the computed cache check bits on their way to the cache write path. The replacement lasts until software clears the force bit.

Top module: `cache_err_router`

## Requirements
- R1: The enable register resets to 0 and is written through `en_we`/`en_wdata`. Only bits 0 (corrected-error enable), 1 (system-error enable), 3 (fast-trap enable) and 4 through 18 (injection fields) are stored. All other bits read back 0 on `en_rdata`, so writing all ones reads back 0x0007FFFB.
- R2: The code encodings are as follows. Class: 0 hardware-corrected, 1 software-correctable, 2 uncorrectable, 3 timeout, 4 bus error. Source: 0 cache data, 1 cache tag, 2 bus data, 3 bus tag. Operation: 0 instruction fetch, 1 load, 2 atomic, 3 store merge, 4 writeback, 5 copyout, 6 vector fetch. `trap_fast` pulses when all of the following hold: enable bit 3 is set, the class is 1 or 2, the source is a cache source, and the operation is 0, 1 or 2.
- R3: A cache error during store merge, writeback or copyout never raises `trap_fast`, whatever the enables.
- R4: A bus-source system error has class 2, 3 or 4. With enable bit 1 set, such an error raises `trap_iacc` on an instruction fetch, and raises `trap_dacc` on a load or atomic.
- R5: With enable bit 1 set, a bus-source system error during store merge, writeback or copyout raises the disrupting trap (`trap_disr`), and no synchronous trap.
- R6: With enable bit 0 set, a class 0 error raises the disrupting trap in two cases: on a bus-source read (operation 0 to 2), or on store merge, writeback or copyout from any source. A class 0 cache-source read raises no trap.
- R7: On a vector fetch (operation 6), a bus system error with bit 1 set, or a class 0 error with bit 0 set, raises only the disrupting trap.
- R8: Every valid report with class 0 to 4 sets status bit `class*4+source` the cycle after it arrives. This happens even when all enables are 0, and such reports raise no trap.
- R9: Status bits are write-one-to-clear through `stat_clr`, and other bits are unaffected. If the same bit is set and cleared in one cycle, it stays 1.
- R10: Every trap output changes the cycle after its report. At most one synchronous trap pulses per cycle. When several are hit at once, fast beats instruction-access, which beats data-access.
- R11: `trap_disr` stays high until `disr_ack`. An acknowledge that arrives together with a new disrupting hit leaves it high. While a synchronous trap pulses, `trap_disr` is low and the trap stays pending. It is raised in the next cycle.
- R12: With bit 13 set, `wr_data_ecc` carries bits 12:4 in place of `calc_data_ecc`. With bit 18 set, `wr_tag_ecc` carries bits 17:14 in place of `calc_tag_ecc`. When a force bit is clear, the computed value passes through unchanged.
- R13: With the matching enable bit clear, an event raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | REG_W | Enable register write data |
| en_rdata | output | REG_W | Enable register contents |
| ev_valid | input | NLANE | Per-lane report valid |
| ev_class | input | 3*NLANE | Per-lane class code |
| ev_src | input | 2*NLANE | Per-lane source code |
| ev_op | input | 3*NLANE | Per-lane operation code |
| stat_clr | input | 20 | Write-one-to-clear mask for status |
| stat_q | output | 20 | Sticky status bits |
| disr_ack | input | 1 | Acknowledge of the disrupting trap |
| trap_fast | output | 1 | Fast cache-error trap pulse |
| trap_iacc | output | 1 | Instruction-access-error trap pulse |
| trap_dacc | output | 1 | Data-access-error trap pulse |
| trap_disr | output | 1 | Disrupting ECC trap level |
| calc_data_ecc | input | 9 | Computed data check bits |
| calc_tag_ecc | input | 4 | Computed tag check bits |
| wr_data_ecc | output | 9 | Data check bits sent to the cache |
| wr_tag_ecc | output | 4 | Tag check bits sent to the cache |

## Verification
The key collision is between a synchronous trap and a pending disrupting trap in the same cycle. The bench provokes it by putting a load system error on one lane and a writeback system error on the other in the same cycle. It then expects `trap_dacc` high with `trap_disr` low, and one cycle later the reverse. A second collision puts a status clear on the same cycle as the event that sets the bit, and puts a disrupting acknowledge on the same cycle as a new disrupting hit. In both cases the bench expects the set to win at the ports.

// File: rtl/cer_pkg.sv
`timescale 1ns/1ps
package cer_pkg;
    localparam int CLS_W  = 3;
    localparam int SRC_W  = 2;
    localparam int OP_W   = 3;
    localparam int N_CLS  = 5;
    localparam int N_SRC  = 4;
    localparam int ST_W   = N_CLS * N_SRC;
    localparam int DECC_W = 9;
    localparam int TECC_W = 4;

    // enable register field positions (decoded by software)
    localparam int EN_CE    = 0;
    localparam int EN_NC    = 1;
    localparam int EN_FAST  = 3;
    localparam int DVAL_LO  = 4;
    localparam int DFORCE   = 13;
    localparam int TVAL_LO  = 14;
    localparam int TFORCE   = 18;

    typedef enum logic [CLS_W-1:0] {
        CL_HWCOR = 3'd0, CL_SWCOR = 3'd1, CL_UNCOR = 3'd2,
        CL_TMO   = 3'd3, CL_BERR  = 3'd4
    } cls_e;

    typedef enum logic [SRC_W-1:0] {
        SR_CDATA = 2'd0, SR_CTAG = 2'd1, SR_BDATA = 2'd2, SR_BTAG = 2'd3
    } src_e;

    typedef enum logic [OP_W-1:0] {
        OP_IFETCH = 3'd0, OP_LOAD  = 3'd1, OP_ATOMIC  = 3'd2, OP_MERGE = 3'd3,
        OP_WBACK  = 3'd4, OP_COPYOUT = 3'd5, OP_IVEC = 3'd6
    } op_e;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0, DS_PEND = 2'd1, DS_HELD = 2'd2
    } dstate_e;
endpackage

// File: rtl/cer_classify.sv
`timescale 1ns/1ps
module cer_classify
    import cer_pkg::*;
(
    input  logic              valid,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic [SRC_W-1:0]  src_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic              en_ce,
    input  logic              en_nc,
    input  logic              en_fast,
    output logic              hit_fast,
    output logic              hit_iacc,
    output logic              hit_dacc,
    output logic              hit_disr,
    output logic [ST_W-1:0]   stat_set
);
    cls_e cls;
    op_e  op;
    logic from_bus, rd_op, flush_op, vec_op, sys_err, fix_err, soft_or_hard;

    always_comb begin
        cls          = cls_e'(cls_i);
        op           = op_e'(op_i);
        from_bus     = src_i[1];
        rd_op        = (op == OP_IFETCH) || (op == OP_LOAD) || (op == OP_ATOMIC);
        flush_op     = (op == OP_MERGE) || (op == OP_WBACK) || (op == OP_COPYOUT);
        vec_op       = (op == OP_IVEC);
        soft_or_hard = (cls == CL_SWCOR) || (cls == CL_UNCOR);
        sys_err      = from_bus && ((cls == CL_UNCOR) || (cls == CL_TMO) || (cls == CL_BERR));
        fix_err      = (cls == CL_HWCOR);

        hit_fast = valid && en_fast && !from_bus && soft_or_hard && rd_op;
        hit_iacc = valid && en_nc && sys_err && (op == OP_IFETCH);
        hit_dacc = valid && en_nc && sys_err && ((op == OP_LOAD) || (op == OP_ATOMIC));
        hit_disr = valid && ((en_nc && sys_err && (flush_op || vec_op)) ||
                             (en_ce && fix_err && ((from_bus && rd_op) || flush_op || vec_op)));

        stat_set = '0;
        if (valid && (int'(cls_i) < N_CLS))
            stat_set[int'(cls_i) * N_SRC + int'(src_i)] = 1'b1;
    end
endmodule

// File: rtl/cer_ctrl.sv
`timescale 1ns/1ps
module cer_ctrl
    import cer_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  en_q,
    input  logic [DECC_W-1:0] calc_d,
    input  logic [TECC_W-1:0] calc_t,
    output logic [DECC_W-1:0] out_d,
    output logic [TECC_W-1:0] out_t
);
    localparam logic [REG_W-1:0] IMPL_MASK = REG_W'(
        (1 << EN_CE) | (1 << EN_NC) | (1 << EN_FAST) |
        (((1 << DECC_W) - 1) << DVAL_LO) | (1 << DFORCE) |
        (((1 << TECC_W) - 1) << TVAL_LO) | (1 << TFORCE));

    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (we) en_q <= wdata & IMPL_MASK;
    end

    always_comb begin
        out_d = en_q[DFORCE] ? en_q[DVAL_LO +: DECC_W] : calc_d;
        out_t = en_q[TFORCE] ? en_q[TVAL_LO +: TECC_W] : calc_t;
    end

    // injection value follows the force field, not the computed bits
    p_force_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[DFORCE] && $stable(en_q)) |-> (out_d == $past(out_d)));
    p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_q & ~IMPL_MASK) == '0));
endmodule

// File: rtl/cer_status.sv
`timescale 1ns/1ps
module cer_status
    import cer_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] set_i,
    input  logic [ST_W-1:0] clr_i,
    output logic [ST_W-1:0] stat_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(stat_q & ~clr_i)) == $past(stat_q & ~clr_i)));
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/cer_trap_seq.sv
`timescale 1ns/1ps
module cer_trap_seq
    import cer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_fast,
    input  logic hit_iacc,
    input  logic hit_dacc,
    input  logic hit_disr,
    input  logic ack,
    output logic trap_fast,
    output logic trap_iacc,
    output logic trap_dacc,
    output logic trap_disr
);
    dstate_e st_q, st_d;
    logic    sync_hit;
    logic [2:0] sync_q;

    assign sync_hit = hit_fast || hit_iacc || hit_dacc;

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DS_IDLE: if (hit_disr) st_d = sync_hit ? DS_HELD : DS_PEND;
            DS_PEND: begin
                if (sync_hit)                st_d = DS_HELD;
                else if (ack && !hit_disr)   st_d = DS_IDLE;
            end
            DS_HELD: if (!sync_hit) st_d = DS_PEND;
            default: st_d = DS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= DS_IDLE;
        else        st_q <= st_d;
    end

    // synchronous trap pulses with fixed priority
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {hit_fast,
                               hit_iacc && !hit_fast,
                               hit_dacc && !hit_fast && !hit_iacc};
    end

    // outputs
    always_comb begin
        trap_fast = sync_q[2];
        trap_iacc = sync_q[1];
        trap_dacc = sync_q[0];
        trap_disr = (st_q == DS_PEND);
    end

    p_sync_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_fast, trap_iacc, trap_dacc}));
    p_disr_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_fast || trap_iacc || trap_dacc) |-> !trap_disr);
    p_hold_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DS_PEND && !ack) |=> (st_q != DS_IDLE));
    p_pulse_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!hit_fast) |-> !trap_fast);
endmodule

// File: rtl/cache_err_router.sv
`timescale 1ns/1ps
module cache_err_router
    import cer_pkg::*;
#(
    parameter int NLANE = 2,
    parameter int REG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en_we,
    input  logic [REG_W-1:0]       en_wdata,
    output logic [REG_W-1:0]       en_rdata,
    input  logic [NLANE-1:0]       ev_valid,
    input  logic [CLS_W*NLANE-1:0] ev_class,
    input  logic [SRC_W*NLANE-1:0] ev_src,
    input  logic [OP_W*NLANE-1:0]  ev_op,
    input  logic [ST_W-1:0]        stat_clr,
    output logic [ST_W-1:0]        stat_q,
    input  logic                   disr_ack,
    output logic                   trap_fast,
    output logic                   trap_iacc,
    output logic                   trap_dacc,
    output logic                   trap_disr,
    input  logic [DECC_W-1:0]      calc_data_ecc,
    input  logic [TECC_W-1:0]      calc_tag_ecc,
    output logic [DECC_W-1:0]      wr_data_ecc,
    output logic [TECC_W-1:0]      wr_tag_ecc
);
    logic [NLANE-1:0] l_fast, l_iacc, l_dacc, l_disr;
    logic [ST_W-1:0]  l_set [NLANE];
    logic [ST_W-1:0]  set_all;

    cer_ctrl #(.REG_W(REG_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(en_we), .wdata(en_wdata), .en_q(en_rdata),
        .calc_d(calc_data_ecc), .calc_t(calc_tag_ecc),
        .out_d(wr_data_ecc), .out_t(wr_tag_ecc)
    );

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        cer_classify u_cls (
            .valid   (ev_valid[g]),
            .cls_i   (ev_class[g*CLS_W +: CLS_W]),
            .src_i   (ev_src[g*SRC_W +: SRC_W]),
            .op_i    (ev_op[g*OP_W +: OP_W]),
            .en_ce   (en_rdata[EN_CE]),
            .en_nc   (en_rdata[EN_NC]),
            .en_fast (en_rdata[EN_FAST]),
            .hit_fast(l_fast[g]),
            .hit_iacc(l_iacc[g]),
            .hit_dacc(l_dacc[g]),
            .hit_disr(l_disr[g]),
            .stat_set(l_set[g])
        );
    end

    always_comb begin
        set_all = '0;
        for (int i = 0; i < NLANE; i++) set_all = set_all | l_set[i];
    end

    cer_status u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(set_all), .clr_i(stat_clr), .stat_q(stat_q)
    );

    cer_trap_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .hit_fast(|l_fast), .hit_iacc(|l_iacc), .hit_dacc(|l_dacc), .hit_disr(|l_disr),
        .ack(disr_ack),
        .trap_fast(trap_fast), .trap_iacc(trap_iacc),
        .trap_dacc(trap_dacc), .trap_disr(trap_disr)
    );

    p_no_trap_disabled_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (en_rdata[EN_FAST] == 1'b0 && en_rdata[EN_NC] == 1'b0 && !en_we)
            |=> !(trap_fast || trap_iacc || trap_dacc));
    p_fast_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        trap_fast |-> $past(en_rdata[EN_FAST]));
endmodule

// File: tb/cache_err_router_bench.sv
`timescale 1ns/1ps
module cache_err_router_bench;
    localparam int NLANE = 2;
    localparam int REG_W = 32;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        en_we = 0;
    logic [31:0] en_wdata = 0;
    logic [31:0] en_rdata;
    logic [1:0]  ev_valid = 0;
    logic [5:0]  ev_class = 0;
    logic [3:0]  ev_src = 0;
    logic [5:0]  ev_op = 0;
    logic [19:0] stat_clr = 0;
    logic [19:0] stat_q;
    logic        disr_ack = 0;
    logic        trap_fast, trap_iacc, trap_dacc, trap_disr;
    logic [8:0]  calc_data_ecc = 0;
    logic [3:0]  calc_tag_ecc = 0;
    logic [8:0]  wr_data_ecc;
    logic [3:0]  wr_tag_ecc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cache_err_router #(.NLANE(NLANE), .REG_W(REG_W)) u_cache_err_router (
        .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .ev_valid(ev_valid), .ev_class(ev_class), .ev_src(ev_src), .ev_op(ev_op),
        .stat_clr(stat_clr), .stat_q(stat_q), .disr_ack(disr_ack),
        .trap_fast(trap_fast), .trap_iacc(trap_iacc), .trap_dacc(trap_dacc),
        .trap_disr(trap_disr), .calc_data_ecc(calc_data_ecc), .calc_tag_ecc(calc_tag_ecc),
        .wr_data_ecc(wr_data_ecc), .wr_tag_ecc(wr_tag_ecc)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] traps();
        return {trap_fast, trap_iacc, trap_dacc, trap_disr};
    endfunction

    task automatic chk_traps(input string tag, input logic [3:0] exp);
        check(traps() == exp, tag, 32'(traps()), 32'(exp));
    endtask

    // advance one edge, then release all one-cycle inputs
    task automatic tick();
        @(posedge clk); #1;
        ev_valid = 0; en_we = 0; stat_clr = 0; disr_ack = 0;
    endtask

    task automatic ev(input int lane, input int cls, input int src, input int op);
        ev_valid[lane] = 1'b1;
        ev_class[lane*3 +: 3] = 3'(cls);
        ev_src[lane*2 +: 2]   = 2'(src);
        ev_op[lane*3 +: 3]    = 3'(op);
    endtask

    task automatic set_en(input logic [31:0] v);
        en_we = 1; en_wdata = v; tick();
    endtask

    task automatic clean();
        stat_clr = '1; disr_ack = 1; tick(); tick();
    endtask

    task automatic t_reset();
        check(en_rdata == 0, "R1 reset enable", en_rdata, 0);
        check(stat_q == 0, "R8 reset status", 32'(stat_q), 0);
        chk_traps("R10 reset traps", 4'b0000);
        calc_data_ecc = 9'h0C3; calc_tag_ecc = 4'h6; #1;
        check(wr_data_ecc == 9'h0C3 && wr_tag_ecc == 4'h6, "R12 pass-through at reset",
              {19'd0, wr_data_ecc, wr_tag_ecc}, {19'd0, 9'h0C3, 4'h6});
    endtask

    task automatic t_enable();
        set_en(32'hFFFF_FFFF);
        check(en_rdata == 32'h0007_FFFB, "R1 implemented bits", en_rdata, 32'h0007_FFFB);
        set_en(32'h0);
        check(en_rdata == 0, "R1 cleared", en_rdata, 0);
    endtask

    task automatic t_fast();
        set_en(32'h8);
        ev(0, 1, 0, 1); tick();
        chk_traps("R2 swcor cache load fast", 4'b1000);
        tick();
        chk_traps("R10 fast is one pulse", 4'b0000);
        ev(0, 2, 1, 2); tick();
        chk_traps("R2 uncor cache tag atomic fast", 4'b1000);
        ev(0, 2, 2, 1); tick();
        chk_traps("R2 bus source not fast", 4'b0000);
        ev(0, 0, 0, 1); tick();
        chk_traps("R2 hwcor not fast", 4'b0000);
        clean();
    endtask

    task automatic t_flush();
        set_en(32'hB);
        for (int op = 3; op <= 5; op++) begin
            ev(0, 2, 0, op); tick();
            chk_traps("R3 cache flush op no fast", 4'b0000);
        end
        clean();
    endtask

    task automatic t_sync();
        set_en(32'h2);
        ev(0, 2, 2, 0); tick();
        chk_traps("R4 bus uncor ifetch iacc", 4'b0100);
        ev(0, 3, 3, 1); tick();
        chk_traps("R4 bus timeout load dacc", 4'b0010);
        ev(0, 4, 2, 2); tick();
        chk_traps("R4 bus error atomic dacc", 4'b0010);
        set_en(32'h0);
        ev(0, 2, 2, 0); tick();
        chk_traps("R13 disabled no iacc", 4'b0000);
        clean();
    endtask

    task automatic t_disr_nc();
        set_en(32'h2);
        ev(0, 2, 2, 4); tick();
        chk_traps("R5 bus uncor writeback disr", 4'b0001);
        tick();
        chk_traps("R11 disr held without ack", 4'b0001);
        disr_ack = 1; tick();
        chk_traps("R11 ack clears disr", 4'b0000);
        set_en(32'h1);
        ev(0, 2, 2, 4); tick();
        chk_traps("R13 nc disabled no disr", 4'b0000);
        clean();
    endtask

    task automatic t_hwcor();
        set_en(32'h1);
        ev(0, 0, 2, 1); tick();
        chk_traps("R6 hwcor bus load disr", 4'b0001);
        disr_ack = 1; tick();
        ev(0, 0, 0, 3); tick();
        chk_traps("R6 hwcor cache merge disr", 4'b0001);
        disr_ack = 1; tick();
        ev(0, 0, 0, 1); tick();
        chk_traps("R6 hwcor cache load no trap", 4'b0000);
        clean();
    endtask

    task automatic t_ivec();
        set_en(32'h3);
        ev(0, 3, 2, 6); tick();
        chk_traps("R7 vector fetch timeout disr", 4'b0001);
        disr_ack = 1; tick();
        ev(0, 0, 3, 6); tick();
        chk_traps("R7 vector fetch hwcor disr", 4'b0001);
        clean();
    endtask

    task automatic t_log();
        set_en(32'h0);
        ev(0, 4, 3, 4); ev(1, 1, 0, 1); tick();
        check(stat_q == 20'h80010, "R8 logged with enables off", 32'(stat_q), 32'h80010);
        chk_traps("R8 no trap when logging only", 4'b0000);
    endtask

    task automatic t_w1c();
        stat_clr = 20'h80000; ev(0, 4, 3, 4); tick();
        check(stat_q == 20'h80010, "R9 set wins over clear", 32'(stat_q), 32'h80010);
        stat_clr = 20'h80000; tick();
        check(stat_q == 20'h00010, "R9 clear one bit", 32'(stat_q), 32'h10);
        stat_clr = 20'h00010; tick();
        check(stat_q == 0, "R9 clear last bit", 32'(stat_q), 0);
    endtask

    task automatic t_prio();
        set_en(32'hB);
        ev(0, 2, 2, 0); ev(1, 2, 0, 1); tick();
        chk_traps("R10 fast beats iacc", 4'b1000);
        ev(0, 3, 2, 0); ev(1, 2, 2, 1); tick();
        chk_traps("R10 iacc beats dacc", 4'b0100);
        ev(0, 3, 2, 1); ev(1, 2, 2, 4); tick();
        chk_traps("R11 disr masked during dacc", 4'b0010);
        tick();
        chk_traps("R11 disr raised after sync", 4'b0001);
        ev(0, 4, 2, 2); tick();
        chk_traps("R11 pending disr masked by later dacc", 4'b0010);
        tick();
        chk_traps("R11 disr back after mask", 4'b0001);
        disr_ack = 1; ev(0, 0, 2, 4); tick();
        chk_traps("R11 ack with new hit stays", 4'b0001);
        disr_ack = 1; tick();
        chk_traps("R11 ack alone clears", 4'b0000);
        clean();
    endtask

    task automatic t_inject();
        calc_data_ecc = 9'h0F3; calc_tag_ecc = 4'h5;
        set_en((32'h1 << 13) | (32'h1A5 << 4));
        check(wr_data_ecc == 9'h1A5, "R12 data forced", 32'(wr_data_ecc), 32'h1A5);
        check(wr_tag_ecc == 4'h5, "R12 tag passes", 32'(wr_tag_ecc), 32'h5);
        calc_data_ecc = 9'h111; #1;
        check(wr_data_ecc == 9'h1A5, "R12 forced on next write", 32'(wr_data_ecc), 32'h1A5);
        set_en((32'h1 << 18) | (32'hA << 14));
        check(wr_data_ecc == 9'h111, "R12 data released", 32'(wr_data_ecc), 32'h111);
        check(wr_tag_ecc == 4'hA, "R12 tag forced", 32'(wr_tag_ecc), 32'hA);
        set_en(32'h0);
        check(wr_tag_ecc == 4'h5, "R12 tag released", 32'(wr_tag_ecc), 32'h5);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_enable();
        t_fast();
        t_flush();
        t_sync();
        t_disr_nc();
        t_hwcor();
        t_ivec();
        t_log();
        t_w1c();
        t_prio();
        t_inject();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule